// File: doc/BRIEF.md
# Byte DMA Channel with Grouped Source Reload

This block is a single DMA channel that copies bytes from a peripheral data register into memory. Software first sets a source address, a destination address and a transfer count through a small register write port, and then sets the enable bit. A peripheral request then makes the channel ask for the bus. Once the bus is granted, the channel performs read-then-write byte transfers and keeps the bus for as long as the current run lasts. Each transfer reads one byte at the source address and writes it at the destination address. After the write, both addresses advance by one and the count drops by one.

Reload mode lets a small block of peripheral registers be drained over and over into a growing buffer in memory. In this mode transfers run in groups of four. After the fourth write of a group, the source address returns to its programmed start and the channel releases the bus. Every group needs a new peripheral request. The destination address and the count keep advancing across groups. When the count reaches zero, the channel sets a done flag and clears its own enable bit. If the interrupt-enable bit is set, the interrupt output stays high until software clears the done flag.

Top module: `dma_reload_chan`

## Requirements
- R1: While reset is active and after it is released, `bus_req`, `bus_rd`, `bus_wr` and `irq` are low until a transfer is started.
- R2: A transfer is a read cycle at the source address followed by a write cycle at the destination address. The write carries the byte that was read. After the write, both addresses advance by one, except where R5 applies.
- R3: `bus_rd` and `bus_wr` are raised only in a cycle where `bus_req` and `bus_gnt` are both high. Without a grant, the channel holds its current cycle and waits.
- R4: With reload off, a single request moves the whole count. `bus_req` stays high without a break from the first read to the last write.
- R5: With reload on, the source addresses repeat start, start+1, start+2, start+3 in every group. The destination keeps incrementing across groups.
- R6: With reload off, the source address keeps incrementing past start+3 (start+4, start+5, ...).
- R7: With reload on, `bus_req` drops in the cycle after the fourth write of a group. It stays low until a new peripheral request arrives.
- R8: A `dreq` pulse while the channel is idle is remembered and starts one group as soon as the channel is enabled with a non-zero count. A `dreq` pulse during a group is ignored.
- R9: Each write decrements the count. When the count reaches zero, the channel sets done, clears enable and issues no further bus requests, even if `dreq` arrives. A count of 128 in reload mode completes in 32 groups.
- R10: `irq` equals done AND interrupt-enable. Once raised, it holds until a control write with bit 3 set clears done.
- R11: The register selects on `cfg_sel` are 0 = source start address (this also loads the current source address), 1 = destination, 2 = count and 3 = control. The control bits are: bit0 enable, bit1 reload, bit2 interrupt enable, and bit3 a write-one that clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R11) |
| cfg_wdata | input | AW | Register write data |
| dreq | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Address of the current cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in the read cycle |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The hardest case to reach from the ports is the interaction between a latched request and group boundaries. A request has to arrive while the channel is disabled, and another has to land in the middle of a group. The bench then has to show that the first one starts exactly one group and that the second is lost. The stimulus does this by pulsing `dreq` before the enable write and again a few cycles into a running group. It then idles long enough to show that `bus_req` stays low. Meanwhile the grant is withheld at random, which stretches the read and write phases, and a cycle-level reference model checks each cycle.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CTL_EN  = 0;
  localparam int CTL_REL = 1;
  localparam int CTL_IE  = 2;
  localparam int CTL_CLR = 3;
  localparam int CTL_W   = 4;
endpackage

// File: rtl/dma_rl_regs.sv
module dma_rl_regs
  import dma_rl_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CW-1:0]     cnt_wdata,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              xfer_done,
  output logic              ch_en,
  output logic              rel_en,
  output logic              irq_en,
  output logic              done,
  output logic              cnt_zero,
  output logic              cnt_last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_d, rel_d, ie_d, done_d;
  logic          wr_cnt, wr_ctl;

  assign wr_cnt   = cfg_we && (cfg_sel == SEL_CNT);
  assign wr_ctl   = cfg_we && (cfg_sel == SEL_CTRL);
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    en_d   = ch_en;
    rel_d  = rel_en;
    ie_d   = irq_en;
    done_d = done;
    if (xfer_done) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_last) begin
        done_d = 1'b1;
        en_d   = 1'b0;
      end
    end
    if (wr_cnt) cnt_d = cnt_wdata;
    if (wr_ctl) begin
      en_d  = ctl_wdata[CTL_EN];
      rel_d = ctl_wdata[CTL_REL];
      ie_d  = ctl_wdata[CTL_IE];
      if (ctl_wdata[CTL_CLR]) done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ch_en  <= 1'b0;
      rel_en <= 1'b0;
      irq_en <= 1'b0;
      done   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ch_en  <= en_d;
      rel_en <= rel_d;
      irq_en <= ie_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/dma_rl_addr.sv
module dma_rl_addr
  import dma_rl_pkg::*;
#(
  parameter int AW  = 32,
  parameter int GRP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  input  logic          xfer_done,
  input  logic          rel_en,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] src_base,
  output logic [AW-1:0] dst_cur,
  output logic          grp_last
);
  localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;

  logic [AW-1:0] src_d, base_d, dst_d;
  logic [GW-1:0] grp_q, grp_d;

  assign grp_last = (grp_q == GW'(GRP - 1));

  always_comb begin
    src_d  = src_cur;
    base_d = src_base;
    dst_d  = dst_cur;
    grp_d  = grp_q;
    if (start) grp_d = '0;
    if (xfer_done) begin
      dst_d = dst_cur + AW'(1);
      grp_d = grp_last ? '0 : grp_q + GW'(1);
      src_d = (rel_en && grp_last) ? src_base : src_cur + AW'(1);
    end
    if (cfg_we && (cfg_sel == SEL_SRC)) begin
      src_d  = cfg_wdata;
      base_d = cfg_wdata;
    end
    if (cfg_we && (cfg_sel == SEL_DST)) dst_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cur  <= '0;
      src_base <= '0;
      dst_cur  <= '0;
      grp_q    <= '0;
    end else begin
      src_cur  <= src_d;
      src_base <= base_d;
      dst_cur  <= dst_d;
      grp_q    <= grp_d;
    end
  end
endmodule

// File: rtl/dma_rl_seq.sv
module dma_rl_seq
  import dma_rl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_en,
  input  logic          rel_en,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          grp_last,
  input  logic          dreq,
  input  logic          bus_gnt,
  input  logic [7:0]    bus_rdata,
  input  logic [AW-1:0] src_cur,
  input  logic [AW-1:0] dst_cur,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          start,
  output logic          xfer_done
);
  seq_st_e    st_q, st_d;
  logic       pend_q, pend_d;
  logic [7:0] dat_q, dat_d;
  logic       dat_en;

  assign bus_req   = (st_q != ST_IDLE);
  assign bus_rd    = (st_q == ST_RD) && bus_gnt;
  assign bus_wr    = (st_q == ST_WR) && bus_gnt;
  assign bus_addr  = (st_q == ST_WR) ? dst_cur : src_cur;
  assign bus_wdata = dat_q;
  assign start     = (st_q == ST_IDLE) && pend_q && ch_en && !cnt_zero;
  assign xfer_done = bus_wr;
  assign dat_en    = bus_rd;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    dat_d  = dat_en ? bus_rdata : dat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_RD;
          pend_d = 1'b0;
        end else if (dreq) begin
          pend_d = 1'b1;
        end
      end
      ST_RD: if (bus_gnt) st_d = ST_WR;
      ST_WR: begin
        if (bus_gnt) begin
          if (cnt_last || (rel_en && grp_last)) st_d = ST_IDLE;
          else                                  st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      dat_q  <= dat_d;
    end
  end
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_rl_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int GRP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          ch_en, rel_en, irq_en, done, cnt_zero, cnt_last;
  logic          start, xfer_done, grp_last;
  logic [AW-1:0] src_cur, src_base, dst_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dma_rl_regs #(.CW(CW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cnt_wdata (cfg_wdata[CW-1:0]),
    .ctl_wdata (cfg_wdata[CTL_W-1:0]),
    .xfer_done (xfer_done),
    .ch_en     (ch_en),
    .rel_en    (rel_en),
    .irq_en    (irq_en),
    .done      (done),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  dma_rl_addr #(.AW(AW), .GRP(GRP)) addr_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .start     (start),
    .xfer_done (xfer_done),
    .rel_en    (rel_en),
    .src_cur   (src_cur),
    .src_base  (src_base),
    .dst_cur   (dst_cur),
    .grp_last  (grp_last)
  );

  dma_rl_seq #(.AW(AW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ch_en     (ch_en),
    .rel_en    (rel_en),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .grp_last  (grp_last),
    .dreq      (dreq),
    .bus_gnt   (bus_gnt),
    .bus_rdata (bus_rdata),
    .src_cur   (src_cur),
    .dst_cur   (dst_cur),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .start     (start),
    .xfer_done (xfer_done)
  );

  assign irq = done && irq_en;
endmodule

// File: rtl/dma_rl_chk.sv
module dma_rl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          irq,
  input logic          rel_en,
  input logic          grp_last,
  input logic [AW-1:0] src_cur,
  input logic [AW-1:0] src_base,
  input logic [AW-1:0] dst_cur
);
  AST_CYCLE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_gnt && bus_req)); // R3

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_req && !bus_rd)); // R4

  AST_DST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cfg_we) |=> (dst_cur == $past(dst_cur) + AW'(1))); // R2

  AST_SRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && grp_last && rel_en && !cfg_we) |=> (src_cur == src_base)); // R5

  AST_GROUP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && grp_last && rel_en && !cfg_we) |=> !bus_req); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_we) |=> irq); // R10
endmodule

bind dma_reload_chan dma_rl_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .cfg_we   (cfg_we),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .irq      (irq),
  .rel_en   (rel_en),
  .grp_last (grp_last),
  .src_cur  (src_cur),
  .src_base (src_base),
  .dst_cur  (dst_cur)
);

// File: tb/dma_reload_chan_tb_top.sv
module dma_reload_chan_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          dreq = 1'b0;
  logic          bus_gnt = 1'b0;
  logic          bus_req, bus_rd, bus_wr, irq;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

  dma_reload_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit gnt_rand = 1'b0;

  // behavioural reference
  int          m_ph = 0;   // 0 idle, 1 read phase, 2 write phase
  int          m_cnt = 0;
  int          m_grp = 0;
  bit          m_pend = 0, m_en = 0, m_rel = 0, m_ie = 0, m_done = 0;
  logic [31:0] m_src = 0, m_base = 0, m_dst = 0;
  logic [7:0]  m_dat = 0;

  logic [31:0] rd_q[$];
  logic [31:0] wr_q[$];
  bit          s_req;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic compare();
    bit e_req, e_rd, e_wr, e_irq;
    e_req = (m_ph != 0);
    e_rd  = (m_ph == 1) && bus_gnt;
    e_wr  = (m_ph == 2) && bus_gnt;
    e_irq = m_done && m_ie;
    check(bus_req == e_req, "R7 bus_req", bus_req, e_req);
    check(bus_rd == e_rd,   "R3 bus_rd",  bus_rd,  e_rd);
    check(bus_wr == e_wr,   "R3 bus_wr",  bus_wr,  e_wr);
    check(irq == e_irq,     "R10 irq",    irq,     e_irq);
    if (e_rd) check(bus_addr == m_src, "R5 read address", bus_addr, m_src);
    if (e_wr) begin
      check(bus_addr == m_dst,  "R2 write address", bus_addr, m_dst);
      check(bus_wdata == m_dat, "R2 write data",    bus_wdata, m_dat);
    end
    if (bus_rd) rd_q.push_back(bus_addr);
    if (bus_wr) wr_q.push_back(bus_addr);
    s_req = bus_req;
  endtask

  task automatic model_step();
    if (m_ph == 1 && bus_gnt) begin
      m_dat = m_src[7:0] ^ 8'h5A;
      m_ph  = 2;
    end else if (m_ph == 2 && bus_gnt) begin
      m_cnt = m_cnt - 1;
      m_dst = m_dst + 1;
      if (m_rel && m_grp == 3) m_src = m_base;
      else                     m_src = m_src + 1;
      m_grp = (m_grp + 1) % 4;
      if (m_cnt == 0) begin
        m_done = 1; m_en = 0; m_ph = 0;
      end else if (m_rel && m_grp == 0) m_ph = 0;
      else m_ph = 1;
    end else if (m_ph == 0) begin
      if (m_pend && m_en && m_cnt != 0) begin
        m_ph = 1; m_pend = 0; m_grp = 0;
      end else if (dreq) m_pend = 1;
    end
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin m_src = cfg_wdata; m_base = cfg_wdata; end
        2'd1: m_dst = cfg_wdata;
        2'd2: m_cnt = int'(cfg_wdata[15:0]);
        default: begin
          m_en = cfg_wdata[0]; m_rel = cfg_wdata[1]; m_ie = cfg_wdata[2];
          if (cfg_wdata[3]) m_done = 0;
        end
      endcase
    end
  endtask

  task automatic tick();
    if (gnt_rand) bus_gnt = ($urandom_range(0, 3) != 0);
    #1;
    compare();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    cycles++;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tick();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse_dreq();
    dreq = 1'b1; tick(); dreq = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 10 && m_ph == 0; i++) tick();
  endtask

  task automatic run_group(output int gaps);
    gaps = 0;
    while (m_ph != 0) begin
      tick();
      if (!s_req) gaps++;
    end
  endtask

  task automatic idle_no_req(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (s_req) seen = 1;
    end
    check(!seen, tag, seen, 0);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  initial begin
    int gaps;
    int grp_n;
    bit src_ok;
    // R1 reset state
    repeat (3) tick();
    check(!bus_req && !bus_rd && !bus_wr && !irq, "R1 outputs in reset",
          {bus_req, bus_rd, bus_wr, irq}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(!bus_req && !irq, "R1 outputs after reset", {bus_req, irq}, 0);

    // Scenario A: reload off, 6 transfers, grant held (R2 R4 R6 R9 R10 R11)
    bus_gnt = 1'b1;
    cfg_write(2'd0, 32'h0000_85F0);
    cfg_write(2'd1, 32'h0000_E800);
    cfg_write(2'd2, 32'd6);
    cfg_write(2'd3, 32'h5);            // enable + irq enable
    rd_q.delete(); wr_q.delete();
    pulse_dreq();
    wait_busy();
    run_group(gaps);
    check(gaps == 0, "R4 bus_req unbroken across burst", gaps, 0);
    check(rd_q.size() == 6, "R4 one request moves full count", rd_q.size(), 6);
    for (int i = 0; i < 6 && i < rd_q.size(); i++)
      check(rd_q[i] == 32'h85F0 + i, "R6 source keeps incrementing", rd_q[i], 32'h85F0 + i);
    for (int i = 0; i < 6 && i < wr_q.size(); i++)
      check(wr_q[i] == 32'hE800 + i, "R2 destination advances", wr_q[i], 32'hE800 + i);
    tick();
    check(irq == 1'b1, "R10 irq raised at count end", irq, 1);
    repeat (5) tick();
    check(irq == 1'b1, "R10 irq held until cleared", irq, 1);
    pulse_dreq();
    idle_no_req(8, "R9 no request after count exhausted");
    cfg_write(2'd3, 32'h8);            // clear done
    tick();
    check(irq == 1'b0, "R10 irq cleared by write", irq, 0);

    // Scenario B: reload on, count 12, random grant, irq masked (R5 R7 R8 R10)
    gnt_rand = 1'b1;
    cfg_write(2'd0, 32'h0000_85F0);
    cfg_write(2'd1, 32'h0000_E800);
    cfg_write(2'd2, 32'd12);
    rd_q.delete(); wr_q.delete();
    pulse_dreq();                      // latched while disabled
    idle_no_req(4, "R8 latched request waits for enable");
    cfg_write(2'd3, 32'h3);            // enable + reload, irq masked
    wait_busy();
    check(m_ph != 0 && bus_req, "R8 latched request starts group", bus_req, 1);
    run_group(gaps);
    idle_no_req(6, "R7 bus released after group of four");
    pulse_dreq();
    wait_busy();
    repeat (3) tick();
    dreq = 1'b1; tick(); dreq = 1'b0;  // arrives mid-group
    run_group(gaps);
    idle_no_req(8, "R8 mid-group request ignored");
    pulse_dreq();
    wait_busy();
    run_group(gaps);
    check(rd_q.size() == 12, "R5 reads in three groups", rd_q.size(), 12);
    for (int i = 0; i < 12 && i < rd_q.size(); i++)
      check(rd_q[i] == 32'h85F0 + (i % 4), "R5 source reloads per group", rd_q[i], 32'h85F0 + (i % 4));
    for (int i = 0; i < 12 && i < wr_q.size(); i++)
      check(wr_q[i] == 32'hE800 + i, "R5 destination keeps advancing", wr_q[i], 32'hE800 + i);
    tick();
    check(irq == 1'b0, "R10 irq masked by interrupt enable", irq, 0);
    cfg_write(2'd3, 32'h4);            // irq enable only
    tick();
    check(irq == 1'b1, "R9 done flag set at count zero", irq, 1);
    cfg_write(2'd3, 32'h8);
    tick();
    check(irq == 1'b0, "R10 done cleared", irq, 0);

    // Scenario C: 128 transfers in reload mode (R9 R5)
    cfg_write(2'd0, 32'h0000_1230);
    cfg_write(2'd1, 32'h0000_4000);
    cfg_write(2'd2, 32'd128);
    cfg_write(2'd3, 32'h7);
    rd_q.delete(); wr_q.delete();
    grp_n = 0;
    for (int g = 0; g < 40 && !m_done; g++) begin
      pulse_dreq();
      wait_busy();
      run_group(gaps);
      grp_n++;
    end
    check(grp_n == 32, "R9 128 transfers take 32 groups", grp_n, 32);
    check(wr_q.size() == 128, "R9 total writes", wr_q.size(), 128);
    src_ok = 1;
    foreach (rd_q[i]) if (rd_q[i] != 32'h1230 + (i % 4)) src_ok = 0;
    check(src_ok, "R5 source stays within group window", src_ok, 1);
    if (wr_q.size() == 128)
      check(wr_q[127] == 32'h407F, "R5 last destination", wr_q[127], 32'h407F);
    tick();
    check(irq == 1'b1, "R10 irq after long run", irq, 1);
    summary();
  end
endmodule